// File: doc/BRIEF.md
# USB Device Configuration Register File

This block holds the endpoint setup and the device address for a full-speed USB peripheral. A local microcontroller talks to it with single-cycle commands: an 8-bit command code together with one data byte. Codes in one window store an endpoint configuration byte, codes in a second window return it, and two further codes store and return the device address byte. The stored fields drive the rest of the peripheral directly through a flat configuration bus.

The address the firmware writes is kept in a shadow register. It is not used on the bus until the host acknowledges the zero-length status packet that ends the Set Address request. A USB bus reset forces the address in use to zero and enables the device, but leaves the shadow value as firmware last wrote it. When an endpoint write alters how FIFO memory would be allocated, a one-cycle flush pulse tells the FIFO logic that the contents of every endpoint are no longer valid.

Top module: `usb_cfg_regfile`

## Requirements
- R1: After reset every endpoint configuration byte, the shadow address byte, the active address, the device enable, the flush pulse and the read data are all zero.
- R2: A command with code 0x20+i stores the data byte as configuration of endpoint slot i (slot 0 control OUT, slot 1 control IN, slot k+1 endpoint k for k = 1..14); it appears on `ep_cfg_flat[8*i+7:8*i]` after the clock edge, with bit 7 FIFO enable, bit 6 direction (1 = IN), bit 5 double buffering, bit 4 isochronous and bits 3:0 the size code.
- R3: A command with code 0x30+i places the configuration byte of slot i on `cmd_rdata` after the clock edge; `cmd_rdata` holds its value until the next read-type or unrecognised command.
- R4: An endpoint write that changes bit 7 or bits 3:0 of that slot raises `fifo_flush` for exactly the one cycle after the write edge.
- R5: An endpoint write that changes only bits 6:4, or that repeats the stored bit 7 and bits 3:0, leaves `fifo_flush` low.
- R6: Code 0xB6 stores the data byte in the shadow address register (bit 7 device enable, bits 6:0 address) and marks an address as pending; code 0xB7 returns the shadow byte on `cmd_rdata`. The write alone does not change `dev_addr` or `dev_en`.
- R7: A `status_ack` pulse while an address is pending loads `dev_addr` from shadow bits 6:0 and `dev_en` from shadow bit 7 at that clock edge and clears the pending mark; a `status_ack` with nothing pending changes nothing.
- R8: A `bus_reset` pulse sets `dev_addr` to 0 and `dev_en` to 1 at that clock edge and does not alter the shadow byte read back through 0xB7.
- R9: A `bus_reset` while an address is pending discards the pending mark, so a later `status_ack` leaves `dev_addr` at 0.
- R10: Any code outside 0x20..0x3F, 0xB6 and 0xB7 changes no stored state and sets `cmd_rdata` to 0x00.
- R11: When `bus_reset` and `status_ack` arrive in the same cycle the bus reset wins: `dev_addr` becomes 0 and the pending address is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmd_valid | input | 1 | One command is presented this cycle |
| cmd_code | input | 8 | Command code |
| cmd_wdata | input | 8 | Data byte for write commands |
| cmd_rdata | output | 8 | Data byte returned by the last read-type command |
| status_ack | input | 1 | Host acknowledged a zero-length IN status packet |
| bus_reset | input | 1 | USB bus reset detected |
| dev_addr | output | 7 | Device address in use on the bus |
| dev_en | output | 1 | Device enabled on the bus |
| ep_cfg_flat | output | 128 | Configuration bytes of all sixteen endpoint slots, slot i at bits 8*i+7..8*i |
| fifo_flush | output | 1 | One-cycle pulse: all endpoint FIFO contents are invalid |

## Verification
The bench builds the block with its default parameters: sixteen endpoint slots and the 0x20, 0x30, 0xB6 and 0xB7 code bases. This puts every code of both endpoint windows within reach, including the first and last slot and the neighbours 0x1F, 0x40, 0xB5 and 0xB8 just outside the decoded ranges. With a 7-bit address field it can also check that enable and address load together from one shadow byte, and how reset, acknowledge and a pending address interact cycle by cycle.

// File: rtl/usb_cfg_pkg.sv
package usb_cfg_pkg;

  typedef struct packed {
    logic       fifo_en;
    logic       dir_in;
    logic       dbl_buf;
    logic       iso;
    logic [3:0] size;
  } ep_cfg_t;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_EP_WR,
    CMD_EP_RD,
    CMD_ADR_WR,
    CMD_ADR_RD,
    CMD_BAD
  } cmd_kind_e;

endpackage

// File: rtl/usb_cmd_decode.sv
module usb_cmd_decode
  import usb_cfg_pkg::*;
#(
  parameter int         NUM_EP     = 16,
  parameter logic [7:0] EP_WR_BASE = 8'h20,
  parameter logic [7:0] EP_RD_BASE = 8'h30,
  parameter logic [7:0] ADR_WR     = 8'hB6,
  parameter logic [7:0] ADR_RD     = 8'hB7,
  localparam int        IDX_W      = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic             cmd_valid,
  input  logic [7:0]       cmd_code,
  output cmd_kind_e        kind,
  output logic [IDX_W-1:0] ep_idx
);

  function automatic logic in_window(input logic [7:0] c, input logic [7:0] b);
    return (int'(c) >= int'(b)) && (int'(c) < int'(b) + NUM_EP);
  endfunction

  always_comb begin
    kind   = CMD_NONE;
    ep_idx = '0;
    if (cmd_valid) begin
      if (in_window(cmd_code, EP_WR_BASE)) begin
        kind   = CMD_EP_WR;
        ep_idx = IDX_W'(cmd_code - EP_WR_BASE);
      end else if (in_window(cmd_code, EP_RD_BASE)) begin
        kind   = CMD_EP_RD;
        ep_idx = IDX_W'(cmd_code - EP_RD_BASE);
      end else if (cmd_code == ADR_WR) begin
        kind = CMD_ADR_WR;
      end else if (cmd_code == ADR_RD) begin
        kind = CMD_ADR_RD;
      end else begin
        kind = CMD_BAD;
      end
    end
  end

endmodule

// File: rtl/usb_ep_cfg_bank.sv
module usb_ep_cfg_bank
  import usb_cfg_pkg::*;
#(
  parameter int  NUM_EP = 16,
  localparam int IDX_W  = (NUM_EP > 1) ? $clog2(NUM_EP) : 1,
  localparam int CFG_W  = $bits(ep_cfg_t)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  ep_cfg_t               wr_data,
  input  logic [IDX_W-1:0]      rd_idx,
  output ep_cfg_t               rd_data,
  output logic [NUM_EP*CFG_W-1:0] cfg_flat,
  output logic                  flush
);

  ep_cfg_t     cfg_q [NUM_EP];
  logic [NUM_EP-1:0] alloc_chg;
  logic        flush_d, flush_q;

  for (genvar g = 0; g < NUM_EP; g++) begin : g_slot
    logic    hit;
    ep_cfg_t cfg_d;

    assign hit = wr_en && (wr_idx == IDX_W'(g));

    always_comb begin
      cfg_d = cfg_q[g];
      if (hit) cfg_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q[g] <= '0;
      else        cfg_q[g] <= cfg_d;
    end

    assign alloc_chg[g] = hit &&
                          ((wr_data.fifo_en != cfg_q[g].fifo_en) ||
                           (wr_data.size    != cfg_q[g].size));

    assign cfg_flat[g*CFG_W +: CFG_W] = cfg_q[g];
  end

  assign flush_d = |alloc_chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flush_q <= 1'b0;
    else        flush_q <= flush_d;
  end

  assign rd_data = cfg_q[rd_idx];
  assign flush   = flush_q;

endmodule

// File: rtl/usb_addr_ctrl.sv
module usb_addr_ctrl #(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W:0]   wr_data,
  input  logic              status_ack,
  input  logic              bus_reset,
  output logic [ADDR_W:0]   shadow,
  output logic              pending,
  output logic [ADDR_W-1:0] active_addr,
  output logic              active_en
);

  logic [ADDR_W:0]   shadow_d, shadow_q;
  logic              pend_d, pend_q;
  logic [ADDR_W-1:0] addr_d, addr_q;
  logic              en_d, en_q;

  always_comb begin
    shadow_d = shadow_q;
    if (wr_en) shadow_d = wr_data;

    pend_d = pend_q;
    if (wr_en)           pend_d = 1'b1;
    else if (bus_reset)  pend_d = 1'b0;
    else if (status_ack) pend_d = 1'b0;

    addr_d = addr_q;
    en_d   = en_q;
    if (bus_reset) begin
      addr_d = '0;
      en_d   = 1'b1;
    end else if (status_ack && pend_q) begin
      addr_d = shadow_q[ADDR_W-1:0];
      en_d   = shadow_q[ADDR_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      pend_q   <= 1'b0;
      addr_q   <= '0;
      en_q     <= 1'b0;
    end else begin
      shadow_q <= shadow_d;
      pend_q   <= pend_d;
      addr_q   <= addr_d;
      en_q     <= en_d;
    end
  end

  assign shadow      = shadow_q;
  assign pending     = pend_q;
  assign active_addr = addr_q;
  assign active_en   = en_q;

endmodule

// File: rtl/usb_cfg_regfile.sv
module usb_cfg_regfile
  import usb_cfg_pkg::*;
#(
  parameter int         NUM_EP     = 16,
  parameter int         ADDR_W     = 7,
  parameter logic [7:0] EP_WR_BASE = 8'h20,
  parameter logic [7:0] EP_RD_BASE = 8'h30,
  parameter logic [7:0] ADR_WR     = 8'hB6,
  parameter logic [7:0] ADR_RD     = 8'hB7,
  localparam int        IDX_W      = (NUM_EP > 1) ? $clog2(NUM_EP) : 1,
  localparam int        CFG_W      = $bits(ep_cfg_t)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_valid,
  input  logic [7:0]              cmd_code,
  input  logic [7:0]              cmd_wdata,
  output logic [7:0]              cmd_rdata,
  input  logic                    status_ack,
  input  logic                    bus_reset,
  output logic [ADDR_W-1:0]       dev_addr,
  output logic                    dev_en,
  output logic [NUM_EP*CFG_W-1:0] ep_cfg_flat,
  output logic                    fifo_flush
);

  cmd_kind_e        kind;
  logic [IDX_W-1:0] ep_idx;
  ep_cfg_t          ep_rd;
  logic [ADDR_W:0]  addr_shadow;
  logic             addr_pending;
  logic [7:0]       rdata_d, rdata_q;

  usb_cmd_decode #(
    .NUM_EP    (NUM_EP),
    .EP_WR_BASE(EP_WR_BASE),
    .EP_RD_BASE(EP_RD_BASE),
    .ADR_WR    (ADR_WR),
    .ADR_RD    (ADR_RD)
  ) u_dec (
    .cmd_valid(cmd_valid),
    .cmd_code (cmd_code),
    .kind     (kind),
    .ep_idx   (ep_idx)
  );

  usb_ep_cfg_bank #(
    .NUM_EP(NUM_EP)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (kind == CMD_EP_WR),
    .wr_idx  (ep_idx),
    .wr_data (ep_cfg_t'(cmd_wdata)),
    .rd_idx  (ep_idx),
    .rd_data (ep_rd),
    .cfg_flat(ep_cfg_flat),
    .flush   (fifo_flush)
  );

  usb_addr_ctrl #(
    .ADDR_W(ADDR_W)
  ) u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (kind == CMD_ADR_WR),
    .wr_data    (cmd_wdata[ADDR_W:0]),
    .status_ack (status_ack),
    .bus_reset  (bus_reset),
    .shadow     (addr_shadow),
    .pending    (addr_pending),
    .active_addr(dev_addr),
    .active_en  (dev_en)
  );

  always_comb begin
    rdata_d = rdata_q;
    case (kind)
      CMD_EP_RD:  rdata_d = 8'(ep_rd);
      CMD_ADR_RD: rdata_d = 8'(addr_shadow);
      CMD_BAD:    rdata_d = '0;
      default:    rdata_d = rdata_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign cmd_rdata = rdata_q;

endmodule

// File: rtl/usb_cfg_regfile_chk.sv
module usb_cfg_regfile_chk #(
  parameter int         NUM_EP     = 16,
  parameter int         ADDR_W     = 7,
  parameter logic [7:0] EP_WR_BASE = 8'h20,
  parameter logic [7:0] EP_RD_BASE = 8'h30,
  parameter logic [7:0] ADR_WR     = 8'hB6,
  parameter logic [7:0] ADR_RD     = 8'hB7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [7:0]        cmd_code,
  input logic [7:0]        cmd_rdata,
  input logic              status_ack,
  input logic              bus_reset,
  input logic [ADDR_W-1:0] dev_addr,
  input logic              dev_en,
  input logic              fifo_flush,
  input logic              addr_pending,
  input logic [ADDR_W:0]   addr_shadow
);

  logic ep_wr_cmd, known_cmd, adr_wr_cmd;

  assign ep_wr_cmd  = cmd_valid && (int'(cmd_code) >= int'(EP_WR_BASE)) &&
                      (int'(cmd_code) < int'(EP_WR_BASE) + NUM_EP);
  assign adr_wr_cmd = cmd_valid && (cmd_code == ADR_WR);
  assign known_cmd  = ep_wr_cmd || adr_wr_cmd || (cmd_code == ADR_RD) ||
                      ((int'(cmd_code) >= int'(EP_RD_BASE)) &&
                       (int'(cmd_code) < int'(EP_RD_BASE) + NUM_EP));

  // R4: a flush pulse is always caused by an endpoint write one cycle earlier
  p_flush_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fifo_flush) |-> $past(ep_wr_cmd));

  // R4: without a new endpoint write the pulse lasts one cycle
  p_flush_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush && !ep_wr_cmd |=> !fifo_flush);

  // R7: no reset and no acknowledge keeps the active address steady
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_reset && !status_ack |=> $stable(dev_addr) && $stable(dev_en));

  // R7: acknowledge with a pending address loads the shadow value
  p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    status_ack && addr_pending && !bus_reset |=>
      (dev_addr == $past(addr_shadow[ADDR_W-1:0])) && (dev_en == $past(addr_shadow[ADDR_W])));

  // R8: bus reset zeroes the address and enables the device
  p_busrst_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> (dev_addr == '0) && dev_en);

  // R8: bus reset leaves the shadow byte alone
  p_shadow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset && !adr_wr_cmd |=> $stable(addr_shadow));

  // R9: bus reset drops a pending address
  p_rstpend_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset && !adr_wr_cmd |=> !addr_pending);

  // R10: unrecognised codes read back as zero
  p_unknown_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !known_cmd |=> cmd_rdata == 8'h00);

endmodule

bind usb_cfg_regfile usb_cfg_regfile_chk #(
  .NUM_EP    (NUM_EP),
  .ADDR_W    (ADDR_W),
  .EP_WR_BASE(EP_WR_BASE),
  .EP_RD_BASE(EP_RD_BASE),
  .ADR_WR    (ADR_WR),
  .ADR_RD    (ADR_RD)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid   (cmd_valid),
  .cmd_code    (cmd_code),
  .cmd_rdata   (cmd_rdata),
  .status_ack  (status_ack),
  .bus_reset   (bus_reset),
  .dev_addr    (dev_addr),
  .dev_en      (dev_en),
  .fifo_flush  (fifo_flush),
  .addr_pending(addr_pending),
  .addr_shadow (addr_shadow)
);

// File: tb/usb_cfg_regfile_bench.sv
`timescale 1ns/1ps
module usb_cfg_regfile_bench;

  localparam int NUM_EP = 16;

  logic         clk;
  logic         rst_n;
  logic         cmd_valid;
  logic [7:0]   cmd_code;
  logic [7:0]   cmd_wdata;
  logic [7:0]   cmd_rdata;
  logic         status_ack;
  logic         bus_reset;
  logic [6:0]   dev_addr;
  logic         dev_en;
  logic [127:0] ep_cfg_flat;
  logic         fifo_flush;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;
  logic [7:0] exp_cfg [NUM_EP];

  usb_cfg_regfile u_usb_cfg_regfile (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_code   (cmd_code),
    .cmd_wdata  (cmd_wdata),
    .cmd_rdata  (cmd_rdata),
    .status_ack (status_ack),
    .bus_reset  (bus_reset),
    .dev_addr   (dev_addr),
    .dev_en     (dev_en),
    .ep_cfg_flat(ep_cfg_flat),
    .fifo_flush (fifo_flush)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Drive one cycle of inputs at a falling edge, return at the next falling edge
  task automatic step(input logic v, input logic [7:0] code, input logic [7:0] data,
                      input logic ack, input logic brst);
    cmd_valid  = v;
    cmd_code   = code;
    cmd_wdata  = data;
    status_ack = ack;
    bus_reset  = brst;
    @(negedge clk);
    cmd_valid  = 1'b0;
    cmd_code   = 8'h00;
    cmd_wdata  = 8'h00;
    status_ack = 1'b0;
    bus_reset  = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] code, input logic [7:0] data);
    step(1'b1, code, data, 1'b0, 1'b0);
  endtask

  task automatic idle();
    step(1'b0, 8'h00, 8'h00, 1'b0, 1'b0);
  endtask

  task automatic test_reset();
    check("R1 flat", 32'(ep_cfg_flat[31:0]), 32'h0);
    check("R1 flat hi", 32'(ep_cfg_flat[127:96]), 32'h0);
    check("R1 addr", 32'(dev_addr), 32'h0);
    check("R1 en", 32'(dev_en), 32'h0);
    check("R1 flush", 32'(fifo_flush), 32'h0);
    check("R1 rdata", 32'(cmd_rdata), 32'h0);
    cmd(8'hB7, 8'h00);
    check("R1 shadow", 32'(cmd_rdata), 32'h0);
  endtask

  task automatic test_ep_write_read();
    for (int i = 0; i < NUM_EP; i++) begin
      logic [7:0] v;
      logic       fl;
      v  = 8'((i * 37 + 8'h5A) ^ (i << 4));
      fl = (v[7] != exp_cfg[i][7]) || (v[3:0] != exp_cfg[i][3:0]);
      cmd(8'(8'h20 + i), v);
      exp_cfg[i] = v;
      check("R2 slot write", 32'(ep_cfg_flat[i*8 +: 8]), 32'(v));
      check("R4 flush on write", 32'(fifo_flush), 32'(fl));
    end
    for (int i = 0; i < NUM_EP; i++) begin
      check("R2 slot kept", 32'(ep_cfg_flat[i*8 +: 8]), 32'(exp_cfg[i]));
    end
    for (int i = NUM_EP - 1; i >= 0; i--) begin
      cmd(8'(8'h30 + i), 8'hFF);
      check("R3 slot read", 32'(cmd_rdata), 32'(exp_cfg[i]));
    end
    idle();
    check("R3 rdata held", 32'(cmd_rdata), 32'(exp_cfg[0]));
  endtask

  task automatic test_flush();
    logic [7:0] b;
    cmd(8'h25, 8'h00);
    idle();
    exp_cfg[5] = 8'h00;
    b = 8'h83;
    cmd(8'h25, b);
    exp_cfg[5] = b;
    check("R4 enable+size change", 32'(fifo_flush), 32'h1);
    idle();
    check("R4 single cycle", 32'(fifo_flush), 32'h0);
    cmd(8'h25, b ^ 8'h70);
    exp_cfg[5] = b ^ 8'h70;
    check("R5 bits 6:4 only", 32'(fifo_flush), 32'h0);
    cmd(8'h25, exp_cfg[5]);
    check("R5 identical rewrite", 32'(fifo_flush), 32'h0);
    cmd(8'h25, exp_cfg[5] ^ 8'h08);
    exp_cfg[5] = exp_cfg[5] ^ 8'h08;
    check("R4 size only", 32'(fifo_flush), 32'h1);
    cmd(8'h2F, exp_cfg[15] ^ 8'h80);
    exp_cfg[15] = exp_cfg[15] ^ 8'h80;
    check("R4 enable only last slot", 32'(fifo_flush), 32'h1);
    idle();
    check("R4 ends", 32'(fifo_flush), 32'h0);
    check("R2 slot 5", 32'(ep_cfg_flat[47:40]), 32'(exp_cfg[5]));
  endtask

  task automatic test_addr_deferred();
    cmd(8'hB6, 8'hA5);
    check("R6 addr deferred", 32'(dev_addr), 32'h0);
    check("R6 en deferred", 32'(dev_en), 32'h0);
    cmd(8'hB7, 8'h00);
    check("R6 shadow read", 32'(cmd_rdata), 32'hA5);
    idle();
    check("R6 still deferred", 32'(dev_addr), 32'h0);
    step(1'b0, 8'h00, 8'h00, 1'b1, 1'b0);
    check("R7 addr loaded", 32'(dev_addr), 32'h25);
    check("R7 en loaded", 32'(dev_en), 32'h1);
    cmd(8'hB6, 8'h13);
    check("R6 addr held", 32'(dev_addr), 32'h25);
    step(1'b0, 8'h00, 8'h00, 1'b1, 1'b0);
    check("R7 second load addr", 32'(dev_addr), 32'h13);
    check("R7 second load en", 32'(dev_en), 32'h0);
    cmd(8'hB6, 8'h9E);
    step(1'b0, 8'h00, 8'h00, 1'b1, 1'b0);
    check("R7 third load", 32'(dev_addr), 32'h1E);
    step(1'b0, 8'h00, 8'h00, 1'b1, 1'b0);
    check("R7 ack without pending", 32'(dev_addr), 32'h1E);
    check("R7 ack without pending en", 32'(dev_en), 32'h1);
  endtask

  task automatic test_bus_reset();
    cmd(8'hB6, 8'h13);
    step(1'b0, 8'h00, 8'h00, 1'b1, 1'b0);
    check("R7 pre reset", 32'(dev_addr), 32'h13);
    step(1'b0, 8'h00, 8'h00, 1'b0, 1'b1);
    check("R8 addr zero", 32'(dev_addr), 32'h0);
    check("R8 enabled", 32'(dev_en), 32'h1);
    cmd(8'hB7, 8'h00);
    check("R8 shadow kept", 32'(cmd_rdata), 32'h13);
  endtask

  task automatic test_reset_pending();
    cmd(8'hB6, 8'hC4);
    step(1'b0, 8'h00, 8'h00, 1'b0, 1'b1);
    check("R9 addr zero", 32'(dev_addr), 32'h0);
    step(1'b0, 8'h00, 8'h00, 1'b1, 1'b0);
    check("R9 ack ignored", 32'(dev_addr), 32'h0);
    check("R9 en kept", 32'(dev_en), 32'h1);
    cmd(8'hB7, 8'h00);
    check("R9 shadow kept", 32'(cmd_rdata), 32'hC4);
  endtask

  task automatic test_priority();
    cmd(8'hB6, 8'h99);
    step(1'b0, 8'h00, 8'h00, 1'b1, 1'b1);
    check("R11 reset wins addr", 32'(dev_addr), 32'h0);
    check("R11 reset wins en", 32'(dev_en), 32'h1);
    step(1'b0, 8'h00, 8'h00, 1'b1, 1'b0);
    check("R11 pending dropped", 32'(dev_addr), 32'h0);
  endtask

  task automatic test_unknown();
    logic [7:0] codes [4];
    codes = '{8'h1F, 8'h40, 8'hB5, 8'hB8};
    foreach (codes[k]) begin
      cmd(8'h30, 8'h00);
      check("R3 read slot 0", 32'(cmd_rdata), 32'(exp_cfg[0]));
      cmd(codes[k], 8'hFF);
      check("R10 read zero", 32'(cmd_rdata), 32'h0);
      check("R10 no flush", 32'(fifo_flush), 32'h0);
      check("R10 slot 0 kept", 32'(ep_cfg_flat[7:0]), 32'(exp_cfg[0]));
      check("R10 slot 15 kept", 32'(ep_cfg_flat[127:120]), 32'(exp_cfg[15]));
    end
    cmd(8'hB7, 8'h00);
    check("R10 shadow kept", 32'(cmd_rdata), 32'h99);
    check("R10 addr kept", 32'(dev_addr), 32'h0);
  endtask

  initial begin
    rst_n      = 1'b0;
    cmd_valid  = 1'b0;
    cmd_code   = 8'h00;
    cmd_wdata  = 8'h00;
    status_ack = 1'b0;
    bus_reset  = 1'b0;
    for (int i = 0; i < NUM_EP; i++) exp_cfg[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_ep_write_read();
    test_flush();
    test_addr_deferred();
    test_bus_reset();
    test_reset_pending();
    test_priority();
    test_unknown();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule